// File: doc/BRIEF.md
# Sync Timing Format Change Detector

This block watches the horizontal and vertical sync pulses of an incoming video stream and measures two numbers for every frame or field. The first is the line period, counted in clock cycles. The second is the frame height, counted in lines. Each new pair of numbers is compared with the pair captured one frame earlier. If either number has moved by more than its own programmable tolerance, a sticky change flag is raised, and that flag can also drive an interrupt. Firmware uses the flag to notice that the source has switched resolution or refresh rate.

Horizontal and vertical sync edges can land on nearly the same clock cycle. In that case the line that straddles the frame edge can be counted in one frame or in the next, and the line count jitters by one from frame to frame. A select input inserts a fixed 16-cycle delay on the horizontal sync, which moves its edges well clear of the vertical edge.

Sequencing is done by a three-state controller:
- **ST_SYNC**: waits for the first vertical edge after reset. The count collected before that edge covers only part of a frame, so it is discarded. Transition "open" leads to ST_SEED.
- **ST_SEED**: takes the first complete measurement as the reference, without comparing it. Transition "seed" leads to ST_TRACK.
- **ST_TRACK**: handles every later measurement. Transition "compare" evaluates the measurement against the reference and then replaces the reference. The controller stays in ST_TRACK until reset.

Top module: `sync_fmt_watch`

## Requirements
- R1: A rising edge of horizontal sync is one cycle in which `hsync_i` is 1 and was 0 in the cycle before. The line period is the number of clock cycles from one such edge to the next. At each rising edge of `vsync_i`, the period of the most recently completed line is captured as the horizontal measurement.
- R2: The vertical measurement counts the horizontal rising edges from one `vsync_i` rising edge up to, but not including, the next one. A horizontal edge that falls in the same cycle as a vertical edge belongs to the new frame.
- R3: The first vertical edge after reset only opens measurement. The second one produces the first measurement, which becomes the reference and never sets `chg_stat_o`.
- R4: Every later measurement sets `chg_stat_o` when |h − h_ref| > `h_thr_i` or |v − v_ref| > `v_thr_i`. A difference equal to its threshold is not a change.
- R5: After each compare, the reference takes the new measurement. `h_meas_o` and `v_meas_o` show the reference, and they update two clock cycles after the vertical edge.
- R6: `chg_stat_o` stays at 1 until a cycle with `stat_clr_i` = 1. If a new change is detected in the same cycle as the clear, the change wins.
- R7: `irq_o` is 1 exactly when `chg_stat_o` is 1 and `irq_en_i` is 1.
- R8: With `hs_dly_sel_i` = 1, horizontal sync is delayed by 16 clock cycles before both counts. When the vertical edge moves between one cycle before and one cycle after a horizontal edge, this keeps the line count steady.
- R9: After reset, `chg_stat_o`, `irq_o`, `h_meas_o` and `v_meas_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| hs_dly_sel_i | input | 1 | 1 = use horizontal sync delayed by 16 cycles |
| h_thr_i | input | HCNT_W | Horizontal tolerance in clock cycles |
| v_thr_i | input | VCNT_W | Vertical tolerance in lines |
| irq_en_i | input | 1 | Interrupt enable |
| stat_clr_i | input | 1 | Clear pulse for the change flag |
| h_meas_o | output | HCNT_W | Latched line period |
| v_meas_o | output | VCNT_W | Latched lines per frame |
| chg_stat_o | output | 1 | Sticky format change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong reference or a wrong controller state shows up on `h_meas_o`, `v_meas_o` and `chg_stat_o` two cycles after the next vertical edge. It therefore appears within one frame of the fault. A controller that skips the seed step sets the flag on the very first measurement, when the reference is still zero. A counter that assigns the straddling line to the wrong frame shows as a line count off by one. The directed frames place the vertical edge on either side of a horizontal edge so that this case is exercised.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_SEED  = 2'd1,
        ST_TRACK = 2'd2
    } sfw_state_e;
endpackage

// File: rtl/sfw_hs_delay.sv
module sfw_hs_delay #(
    parameter int DEPTH = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_i,
    input  logic hs_i,
    output logic hs_o
);
    logic [DEPTH-1:0] tap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_q <= '0;
        else         tap_q <= {tap_q[DEPTH-2:0], hs_i};
    end

    assign hs_o = sel_i ? tap_q[DEPTH-1] : hs_i;
endmodule

// File: rtl/sfw_period_meter.sv
module sfw_period_meter #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hs_i,
    input  logic          vs_i,
    output logic [HW-1:0] meas_h_o,
    output logic [VW-1:0] meas_v_o,
    output logic          vld_o
);
    localparam logic [HW-1:0] HMAX = {HW{1'b1}};
    localparam logic [VW-1:0] VMAX = {VW{1'b1}};

    logic          hs_q, vs_q;
    logic [HW-1:0] h_cnt, h_per;
    logic [VW-1:0] v_cnt;
    logic          hs_rise, vs_rise;

    assign hs_rise = hs_i & ~hs_q;
    assign vs_rise = vs_i & ~vs_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            h_cnt    <= '0;
            h_per    <= '0;
            v_cnt    <= '0;
            meas_h_o <= '0;
            meas_v_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            hs_q  <= hs_i;
            vs_q  <= vs_i;
            vld_o <= vs_rise;
            if (hs_rise) begin
                h_per <= h_cnt;
                h_cnt <= {{(HW-1){1'b0}}, 1'b1};
            end else if (h_cnt != HMAX) begin
                h_cnt <= h_cnt + 1'b1;
            end
            if (vs_rise) begin
                meas_h_o <= hs_rise ? h_cnt : h_per;
                meas_v_o <= v_cnt;
                v_cnt    <= hs_rise ? {{(VW-1){1'b0}}, 1'b1} : '0;
            end else if (hs_rise && v_cnt != VMAX) begin
                v_cnt <= v_cnt + 1'b1;
            end
        end
    end

    // R1
    hcnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_rise |=> (h_cnt == {{(HW-1){1'b0}}, 1'b1}));
    // R2
    vcnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vs_rise |=> (v_cnt <= {{(VW-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/sfw_ref_fsm.sv
module sfw_ref_fsm
    import sfw_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [HW-1:0] meas_h_i,
    input  logic [VW-1:0] meas_v_i,
    input  logic [HW-1:0] h_thr_i,
    input  logic [VW-1:0] v_thr_i,
    input  logic          clr_i,
    input  logic          irq_en_i,
    output logic [HW-1:0] ref_h_o,
    output logic [VW-1:0] ref_v_o,
    output logic          status_o,
    output logic          irq_o
);
    sfw_state_e    st_q, st_d;
    logic [HW-1:0] dh;
    logic [VW-1:0] dv;
    logic          moved, take_ref, flag_set;

    assign dh = (meas_h_i >= ref_h_o) ? meas_h_i - ref_h_o : ref_h_o - meas_h_i;
    assign dv = (meas_v_i >= ref_v_o) ? meas_v_i - ref_v_o : ref_v_o - meas_v_i;
    assign moved = (dh > h_thr_i) || (dv > v_thr_i);

    always_comb begin
        st_d     = st_q;
        take_ref = 1'b0;
        flag_set = 1'b0;
        unique case (st_q)
            ST_SYNC:  if (vld_i) st_d = ST_SEED;
            ST_SEED:  if (vld_i) begin st_d = ST_TRACK; take_ref = 1'b1; end
            ST_TRACK: if (vld_i) begin take_ref = 1'b1; flag_set = moved; end
            default:  st_d = ST_SYNC;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_SYNC;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_h_o  <= '0;
            ref_v_o  <= '0;
            status_o <= 1'b0;
        end else begin
            if (take_ref) begin
                ref_h_o <= meas_h_i;
                ref_v_o <= meas_v_i;
            end
            status_o <= (status_o & ~clr_i) | flag_set;
        end
    end

    always_comb irq_o = status_o & irq_en_i;

    // R3
    seed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_SEED && vld_i) |=> !status_o);
    // R6
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o && !clr_i) |=> status_o);
    // R5
    ref_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_TRACK && vld_i) |=> (ref_h_o == $past(meas_h_i) && ref_v_o == $past(meas_v_i)));
    // R4
    flag_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_TRACK && vld_i && (dh > h_thr_i)) |=> status_o);
endmodule

// File: rtl/sync_fmt_watch.sv
module sync_fmt_watch #(
    parameter int HCNT_W = 12,
    parameter int VCNT_W = 11,
    parameter int HS_DLY = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              hs_dly_sel_i,
    input  logic [HCNT_W-1:0] h_thr_i,
    input  logic [VCNT_W-1:0] v_thr_i,
    input  logic              irq_en_i,
    input  logic              stat_clr_i,
    output logic [HCNT_W-1:0] h_meas_o,
    output logic [VCNT_W-1:0] v_meas_o,
    output logic              chg_stat_o,
    output logic              irq_o
);
    logic              hs_used;
    logic [HCNT_W-1:0] meas_h;
    logic [VCNT_W-1:0] meas_v;
    logic              meas_vld;

    sfw_hs_delay #(.DEPTH(HS_DLY)) u_dly (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(hs_dly_sel_i),
        .hs_i(hsync_i), .hs_o(hs_used)
    );

    sfw_period_meter #(.HW(HCNT_W), .VW(VCNT_W)) u_meter (
        .clk_i(clk_i), .rst_ni(rst_ni), .hs_i(hs_used), .vs_i(vsync_i),
        .meas_h_o(meas_h), .meas_v_o(meas_v), .vld_o(meas_vld)
    );

    sfw_ref_fsm #(.HW(HCNT_W), .VW(VCNT_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(meas_vld),
        .meas_h_i(meas_h), .meas_v_i(meas_v),
        .h_thr_i(h_thr_i), .v_thr_i(v_thr_i),
        .clr_i(stat_clr_i), .irq_en_i(irq_en_i),
        .ref_h_o(h_meas_o), .ref_v_o(v_meas_o),
        .status_o(chg_stat_o), .irq_o(irq_o)
    );

    // R7
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_o);
endmodule

// File: tb/sync_fmt_watch_test.sv
module sync_fmt_watch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, vsync = 1'b0, dly_sel = 1'b0;
    logic [11:0] h_thr = '0;
    logic [10:0] v_thr = '0;
    logic        irq_en = 1'b0, clr = 1'b0;
    logic [11:0] h_meas;
    logic [10:0] v_meas;
    logic        chg, irq;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    sync_fmt_watch uut (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .hs_dly_sel_i(dly_sel), .h_thr_i(h_thr), .v_thr_i(v_thr),
        .irq_en_i(irq_en), .stat_clr_i(clr),
        .h_meas_o(h_meas), .v_meas_o(v_meas), .chg_stat_o(chg), .irq_o(irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One frame: lines x hper cycles, hsync high 4 cycles per line,
    // vsync rises 'off' cycles after the first line's hsync edge.
    task automatic frame(int lines, int hper, int off, int clr_at);
        for (int c = 0; c < lines * hper; c++) begin
            @(negedge clk);
            hsync = (c % hper) < 4;
            vsync = (c >= off) && (c < off + 8);
            clr   = (c == clr_at);
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R9 status", chg, 0);
        check("R9 irq", irq, 0);
        check("R9 h_meas", h_meas, 0);
        check("R9 v_meas", v_meas, 0);
    endtask

    task automatic t_seed();
        do_reset();
        dly_sel = 0; h_thr = 0; v_thr = 0; irq_en = 1;
        frame(6, 40, 0, -1);
        frame(6, 40, 0, -1);
        check("R3 seed no flag", chg, 0);
        check("R1 h seed", h_meas, 40);
        check("R2 v seed", v_meas, 6);
        frame(6, 40, 0, -1);
        check("R4 equal frames", chg, 0);
    endtask

    task automatic t_hthr();
        do_reset();
        h_thr = 2; v_thr = 0; irq_en = 1;
        frame(6, 40, 0, -1);
        frame(6, 40, 0, -1);
        frame(6, 42, 0, -1);
        frame(6, 45, 0, -1);
        check("R4 h diff equal thr", chg, 0);
        check("R5 h ref follows", h_meas, 42);
        frame(6, 45, 0, -1);
        check("R4 h diff above thr", chg, 1);
        check("R7 irq on", irq, 1);
        check("R5 h ref new", h_meas, 45);
    endtask

    task automatic t_vthr();
        do_reset();
        h_thr = 0; v_thr = 1; irq_en = 0;
        frame(10, 30, 0, -1);
        frame(10, 30, 0, -1);
        frame(11, 30, 0, -1);
        frame(13, 30, 0, -1);
        check("R4 v diff equal thr", chg, 0);
        check("R5 v ref follows", v_meas, 11);
        frame(13, 30, 0, 1);
        check("R6 set wins over clear", chg, 1);
        check("R7 irq masked", irq, 0);
        check("R5 v ref new", v_meas, 13);
    endtask

    task automatic t_clear();
        frame(13, 30, 0, -1);
        check("R6 sticky", chg, 1);
        irq_en = 1;
        #1 check("R7 irq enabled", irq, 1);
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        check("R6 cleared", chg, 0);
        check("R7 irq after clear", irq, 0);
    endtask

    task automatic t_delay(bit use_dly);
        do_reset();
        dly_sel = use_dly; h_thr = 0; v_thr = 0; irq_en = 0;
        frame(6, 40, 1, -1);
        frame(6, 40, 1, -1);
        frame(6, 40, 0, -1);
        if (use_dly) begin
            check("R8 delayed v steady", v_meas, 6);
            check("R8 delayed no flag", chg, 0);
        end else begin
            check("R2 straddle line count", v_meas, 5);
            check("R4 jitter flagged", chg, 1);
        end
        check("R1 h period", h_meas, 40);
        dly_sel = 0;
    endtask

    initial begin
        t_reset();
        t_seed();
        t_hthr();
        t_vthr();
        t_clear();
        t_delay(1'b0);
        t_delay(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule